// File: doc/BRIEF.md
# Far-End Fault Detector and Generator

This block carries in-band far-end fault signalling on a 100 Mb/s fiber link. It works on the serial code-bit stream at one bit per clock. On the receive side it watches the incoming bits for the fault pattern, which is a run of exactly 84 ones closed by a single zero. When three such patterns arrive back to back, it raises a latched remote-fault flag. The flag means that the far end is not receiving this side's transmissions correctly.

On the transmit side the block swaps normal transmit bits for an endless train of fault patterns while the local receive link is down. The link state comes in as a link-valid flag, taken from the detection of valid link words. No separate signal-detect input is used. The block acts only while fiber mode is enabled. In any other mode the flag stays clear and transmit bits pass straight through.

The bit streams are continuous, with one bit on every clock in each direction. There is therefore no valid/ready handshake and no back-pressure: every clock carries a bit, and the block never stalls either stream. The control and status pins are plain levels or strobes.

Top module: `far_fault_unit`

## Requirements
- R1: A detection is exactly 84 consecutive ones on `rx_bit` followed by one zero. The zero bit is the cycle in which the detection is counted.
- R2: `remote_fault` (1 = far end reports a fault) rises only on the third back-to-back detection. It goes high in the cycle after that detection's zero bit, and stays low after only two.
- R3: A run of more than 84 ones before the zero is not a detection. A zero that arrives before the 84th one restarts the run count from zero.
- R4: Each detection must follow the previous one within one pattern length, 85 cycles. If no detection arrives in that window, the occurrence count clears, and a later detection counts as the first.
- R5: `remote_fault` holds high until a cycle with `stat_rd` high, and reads low in the cycle after. A detection that completes the count in the same cycle as `stat_rd` leaves it set, so set wins. Detections after the third keep setting it again.
- R6: While `fiber_en` is high and `rx_link_ok` is low, `tx_bit_out` carries patterns with no gap between them: 84 ones then one zero, repeated. The stream starts in the cycle after link loss is sampled.
- R7: When `rx_link_ok` returns, the pattern in flight finishes through its zero bit. `tx_bit_out` follows `tx_bit_in` from the next cycle on.
- R8: While `fiber_en` is low, `tx_bit_out` equals `tx_bit_in` in the same cycle, no detections are counted, and `remote_fault` reads low in the cycle after `fiber_en` falls.
- R9: Synchronous active-high `rst` clears all counters and `remote_fault`, and puts the transmit path in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fiber_en | input | 1 | Fiber mode enable |
| rx_link_ok | input | 1 | Receive link valid (valid link words seen) |
| rx_bit | input | 1 | Received code bit |
| tx_bit_in | input | 1 | Transmit code bit from upstream |
| stat_rd | input | 1 | Status read strobe, clears the fault flag |
| tx_bit_out | output | 1 | Code bit sent to the line |
| remote_fault | output | 1 | Latched far-end fault flag |

## Verification
The status read strobe and the third detection can fall in the same cycle, and that clash is the one that matters most. The bench first lets three patterns set the flag and clears it with a read. It then sends a fourth back-to-back pattern and raises `stat_rd` exactly on that pattern's closing zero bit. The flag must read high in the following cycle, since set outranks clear. A read on a later cycle with no detection must drop the flag.

// File: rtl/far_fault_pkg.sv
package far_fault_pkg;
  localparam int unsigned FAULT_ONES = 84;  // ones in one fault pattern
  localparam int unsigned FAULT_HITS = 3;   // back-to-back detections needed

  typedef enum logic {
    GEN_PASS = 1'b0,
    GEN_FILL = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/ff_run_detector.sv
module ff_run_detector #(
  parameter int unsigned ONES_LEN = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rx_bit,
  output logic hit
);
  localparam int unsigned CW = $clog2(ONES_LEN + 2);
  localparam logic [CW-1:0] FULL = CW'(ONES_LEN);
  localparam logic [CW-1:0] OVER = CW'(ONES_LEN + 1);

  logic [CW-1:0] run_q;

  // Saturating run counter: OVER marks a run that is too long.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q <= '0;
    end else if (!rx_bit) begin
      run_q <= '0;
    end else if (run_q != OVER) begin
      run_q <= run_q + CW'(1);
    end
  end

  assign hit = en && !rx_bit && (run_q == FULL);

  // R3: the run counter never passes its saturation value
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    run_q <= OVER);

  // R1: a detection is always closed by a zero after at least one one
  p_hit_after_one_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!rx_bit && $past(rx_bit)));
endmodule

// File: rtl/ff_hit_tracker.sv
module ff_hit_tracker #(
  parameter int unsigned HITS    = 3,
  parameter int unsigned PAT_LEN = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hit,
  input  logic rd,
  output logic fault
);
  localparam int unsigned CNTW = $clog2(HITS + 1);
  localparam int unsigned GW   = $clog2(PAT_LEN + 1);
  localparam logic [CNTW-1:0] CNT_TOP  = CNTW'(HITS);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(HITS - 1);
  localparam logic [GW-1:0]   GAP_END  = GW'(PAT_LEN - 1);

  logic [CNTW-1:0] cnt_q;
  logic [GW-1:0]   gap_q;
  logic            fault_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      gap_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (hit) begin
        gap_q <= '0;
        if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CNTW'(1);
      end else if (cnt_q != '0) begin
        if (gap_q == GAP_END) begin
          cnt_q <= '0;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + GW'(1);
        end
      end
      // set outranks the read strobe
      if (hit && (cnt_q >= CNT_LAST)) fault_q <= 1'b1;
      else if (rd)                    fault_q <= 1'b0;
    end
  end

  assign fault = fault_q;

  // R2: occurrence count stays within its limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP);

  // R2: the flag only rises right after a detection
  p_set_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(hit));

  // R5: a read without a detection clears the flag
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit && en) |=> !fault_q);

  // R8: fiber mode off drops the flag
  p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !fault_q);
endmodule

// File: rtl/ff_fault_gen.sv
module ff_fault_gen
  import far_fault_pkg::*;
#(
  parameter int unsigned ONES_LEN = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic link_ok,
  input  logic tx_in,
  output logic tx_out
);
  localparam int unsigned PW = $clog2(ONES_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(ONES_LEN);

  gen_mode_e     mode_q;
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      mode_q <= GEN_PASS;
      pos_q  <= '0;
    end else if (mode_q == GEN_PASS) begin
      if (!link_ok) begin
        mode_q <= GEN_FILL;
        pos_q  <= '0;
      end
    end else if (pos_q == LAST) begin
      pos_q <= '0;
      if (link_ok) mode_q <= GEN_PASS;
    end else begin
      pos_q <= pos_q + PW'(1);
    end
  end

  assign tx_out = (en && mode_q == GEN_FILL) ? (pos_q != LAST) : tx_in;

  // R6: link loss starts the pattern stream in the next cycle
  p_start_on_loss_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !link_ok && mode_q == GEN_PASS) |=> (mode_q == GEN_FILL));

  // R7: a pattern in flight is never cut short while enabled
  p_finish_pattern_r7: assert property (@(posedge clk) disable iff (rst)
    (en && mode_q == GEN_FILL && pos_q != LAST) |=> (mode_q == GEN_FILL));

  // R8: transmit passes through whenever fiber mode is off
  p_pass_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (tx_out == tx_in));
endmodule

// File: rtl/far_fault_unit.sv
module far_fault_unit #(
  parameter int unsigned ONES_LEN = far_fault_pkg::FAULT_ONES,
  parameter int unsigned HITS     = far_fault_pkg::FAULT_HITS
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic rx_link_ok,
  input  logic rx_bit,
  input  logic tx_bit_in,
  input  logic stat_rd,
  output logic tx_bit_out,
  output logic remote_fault
);
  localparam int unsigned PAT_LEN = ONES_LEN + 1;

  logic det_hit;

  ff_run_detector #(.ONES_LEN(ONES_LEN)) u_det (
    .clk    (clk),
    .rst    (rst),
    .en     (fiber_en),
    .rx_bit (rx_bit),
    .hit    (det_hit)
  );

  ff_hit_tracker #(.HITS(HITS), .PAT_LEN(PAT_LEN)) u_trk (
    .clk   (clk),
    .rst   (rst),
    .en    (fiber_en),
    .hit   (det_hit),
    .rd    (stat_rd),
    .fault (remote_fault)
  );

  ff_fault_gen #(.ONES_LEN(ONES_LEN)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .en      (fiber_en),
    .link_ok (rx_link_ok),
    .tx_in   (tx_bit_in),
    .tx_out  (tx_bit_out)
  );

  // R2: the flag never rises out of fiber mode
  p_rise_in_fiber_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_fault) |-> $past(fiber_en));
endmodule

// File: tb/sim_far_fault_unit.sv
module sim_far_fault_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, fiber_en, rx_link_ok, rx_bit, tx_bit_in, stat_rd;
  logic tx_bit_out, remote_fault;
  int   checks = 0;
  int   errs   = 0;

  always #(CLK_P / 2) clk = ~clk;

  far_fault_unit u0 (
    .clk(clk), .rst(rst), .fiber_en(fiber_en), .rx_link_ok(rx_link_ok),
    .rx_bit(rx_bit), .tx_bit_in(tx_bit_in), .stat_rd(stat_rd),
    .tx_bit_out(tx_bit_out), .remote_fault(remote_fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    rx_bit = b;
    @(negedge clk);
  endtask

  task automatic send_run(input int ones);
    for (int i = 0; i < ones; i++) tick(1'b1);
    tick(1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1; fiber_en = 1'b1; rx_link_ok = 1'b1;
    rx_bit = 1'b0; tx_bit_in = 1'b0; stat_rd = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; fiber_en = 1'b1; rx_link_ok = 1'b0;
    rx_bit = 1'b0; tx_bit_in = 1'b1; stat_rd = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 flag in reset", remote_fault, 0);
    check("R9 pass-through in reset (1)", tx_bit_out, 1);
    tx_bit_in = 1'b0; #1;
    check("R9 pass-through in reset (0)", tx_bit_out, 0);
    rx_link_ok = 1'b1; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_detect();
    do_reset();
    send_run(84); send_run(84);
    check("R2 two detections", remote_fault, 0);
    for (int i = 0; i < 84; i++) tick(1'b1);
    check("R2 before third zero", remote_fault, 0);
    tick(1'b0);
    check("R1 third detection sets flag", remote_fault, 1);
  endtask

  task automatic t_run_len();
    do_reset();
    send_run(85); send_run(85); send_run(85);
    check("R3 runs of 85 ignored", remote_fault, 0);
    send_run(83); send_run(83); send_run(83);
    check("R3 runs of 83 ignored", remote_fault, 0);
    send_run(40);
    send_run(84); send_run(84); send_run(84);
    check("R3 run restarts after early zero", remote_fault, 1);
  endtask

  task automatic t_spacing();
    do_reset();
    send_run(84); send_run(84);
    tick(1'b0);
    send_run(84);
    check("R4 gap clears occurrence count", remote_fault, 0);
    send_run(84); send_run(84);
    check("R4 count restarts after gap", remote_fault, 1);
  endtask

  task automatic t_read();
    do_reset();
    send_run(84); send_run(84); send_run(84);
    check("R5 flag set", remote_fault, 1);
    stat_rd = 1'b1; tick(1'b1); stat_rd = 1'b0;
    check("R5 read clears", remote_fault, 0);
    for (int i = 0; i < 83; i++) tick(1'b1);
    check("R5 stays clear", remote_fault, 0);
    stat_rd = 1'b1; tick(1'b0); stat_rd = 1'b0;
    check("R5 set wins over read", remote_fault, 1);
    stat_rd = 1'b1; tick(1'b0); stat_rd = 1'b0;
    check("R5 read without detection clears", remote_fault, 0);
  endtask

  task automatic t_gen();
    int bad = 0;
    int first_bad = -1;
    do_reset();
    tx_bit_in = 1'b1;
    rx_link_ok = 1'b0; #1;
    check("R6 pass-through before loss sampled", tx_bit_out, 1);
    tx_bit_in = 1'b0; #1;
    check("R6 pass-through before loss sampled (0)", tx_bit_out, 0);
    tx_bit_in = 1'b1;
    for (int i = 0; i < 170; i++) begin
      tick(1'b0);
      if (tx_bit_out != ((i % 85 == 84) ? 1'b0 : 1'b1)) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    check("R6 pattern stream mismatches", bad, 0);
    if (bad != 0) $display("  first mismatch at bit %0d", first_bad);
  endtask

  task automatic t_recover();
    do_reset();
    tx_bit_in = 1'b0;
    rx_link_ok = 1'b0;
    for (int i = 0; i < 100; i++) tick(1'b0);
    rx_link_ok = 1'b1;
    for (int i = 100; i < 169; i++) tick(1'b0);
    check("R7 pattern continues after recovery", tx_bit_out, 1);
    tick(1'b0);
    check("R7 closing zero sent", tx_bit_out, 0);
    tx_bit_in = 1'b0;
    tick(1'b0);
    check("R7 pass-through after pattern (0)", tx_bit_out, 0);
    tx_bit_in = 1'b1; #1;
    check("R7 pass-through after pattern (1)", tx_bit_out, 1);
  endtask

  task automatic t_fiber_off();
    do_reset();
    send_run(84); send_run(84); send_run(84);
    check("R8 flag set in fiber mode", remote_fault, 1);
    fiber_en = 1'b0;
    tick(1'b0);
    check("R8 flag drops when fiber off", remote_fault, 0);
    rx_link_ok = 1'b0; tx_bit_in = 1'b1;
    for (int i = 0; i < 5; i++) tick(1'b0);
    check("R8 tx passes 1 with link down", tx_bit_out, 1);
    tx_bit_in = 1'b0; #1;
    check("R8 tx passes 0 with link down", tx_bit_out, 0);
    rx_link_ok = 1'b1;
    send_run(84); send_run(84); send_run(84);
    check("R8 no detection when off", remote_fault, 0);
    fiber_en = 1'b1; tx_bit_in = 1'b1; #1;
    check("R8 generator idle on re-enable", tx_bit_out, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_detect();
    t_run_len();
    t_spacing();
    t_read();
    t_gen();
    t_recover();
    t_fiber_off();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule